// File: doc/BRIEF.md
# Chunked Spare Area Mapper

This block moves the spare (out-of-band) bytes of a flash page between a host byte port and a group of spare buffers in an on-chip buffer RAM. The spare bytes of a page are split into one chunk per 512 bytes of main data. Each chunk lives in its own buffer region, and the regions sit at a fixed stride above a fixed base address. The host sees one linear spare stream. The block turns each position in that stream into the RAM address where the byte is held.

The share of each buffer is the spare size divided by the chunk count, rounded down to an even number. Any bytes left over after the last full chunk go into the final buffer. This makes the mapping non-uniform for a 4096-byte page with a 218-byte spare area.

A transfer is requested with a start offset, a byte length and a direction. The block first works out the per-buffer share, then the starting buffer and position, using one small iterative divider. It then moves one byte per clock under a valid/ready handshake and pulses a completion flag. The RAM is read combinationally: its data answers the address in the same cycle.

Top module: `spare_chunk_mapper`

## Requirements
- R1: The chunk count is `cfg_page_bytes / 512`. The per-buffer share is `cfg_spare_bytes / chunks`, with bit 0 cleared.
- R2: Spare position p maps to buffer `k = min(p / share, 7)`. Its RAM address is `0x1000 + 64*k + (p - k*share)`, so positions past the last full chunk fall into buffer 7 (or the highest buffer the division reaches).
- R3: Consecutive bytes of one transfer move to consecutive positions. When a transfer crosses a buffer boundary, it continues at position 0 of the next buffer.
- R4: All four page/spare pairs give correct addresses over the whole spare area: 512/16, 2048/64, 4096/128 and 4096/218.
- R5: With `start_write`=1, each cycle with `wr_valid` and `wr_ready` both high performs exactly one RAM write (`ram_wen`=1, `ram_wdata`=`wr_data`). A cycle with `wr_valid` low writes nothing and leaves the position unchanged. `rd_valid` stays low for the whole transfer.
- R6: With `start_write`=0, `rd_valid` is high until all bytes have been taken. `rd_data` is the RAM byte at the mapped address. A cycle with `rd_ready` low keeps the address. `wr_ready` and `ram_wen` stay low for the whole transfer.
- R7: `done` is high for exactly one cycle, the cycle after the final byte moves. `start_ready` is high only when the block is idle.
- R8: A request with `start_len`=0 raises `done` in the cycle after acceptance, with no RAM write and no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_page_bytes | input | 13 | Main page size in bytes |
| cfg_spare_bytes | input | 8 | Spare area size in bytes |
| start_valid | input | 1 | Transfer request |
| start_ready | output | 1 | Idle, request is taken |
| start_offset | input | 8 | First spare position |
| start_len | input | 9 | Byte count |
| start_write | input | 1 | 1: host to RAM, 0: RAM to host |
| wr_valid | input | 1 | Host byte offered |
| wr_ready | output | 1 | Block takes host byte |
| wr_data | input | 8 | Host byte |
| rd_valid | output | 1 | Byte offered to host |
| rd_ready | input | 1 | Host takes byte |
| rd_data | output | 8 | Byte to host |
| ram_addr | output | 13 | Buffer RAM byte address |
| ram_wen | output | 1 | Buffer RAM write strobe |
| ram_wdata | output | 8 | Buffer RAM write data |
| ram_rdata | input | 8 | Buffer RAM read data (combinational) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The mapping is tried with each of the four page/spare pairs over the whole spare area. A pair whose share divides evenly is told apart from the 218-byte case, where the even rounding and the spill into buffer 7 show.

Short directed transfers that start just before a buffer edge show whether the walk restarts at position 0 of the next buffer. Transfers that start deep in the spill region show whether the clamp is applied.

Random offsets, lengths, directions and stall rates on the host side separate handshake faults (a byte moved or skipped during a stall) from address faults. Zero-length requests show whether completion is signalled without RAM traffic.

// File: rtl/spmap_pkg.sv
package spmap_pkg;

  // Transfer sequencer states
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,  // waiting for a request
    ST_DIV_SHARE = 2'd1,  // spare bytes / chunk count
    ST_DIV_POS   = 2'd2,  // start offset / per-buffer share
    ST_MOVE      = 2'd3   // byte-per-cycle transfer
  } spmap_state_e;

endpackage

// File: rtl/spmap_divider.sv
// Restoring divider, one quotient bit per cycle. A go pulse loads the
// operands; fin pulses for one cycle once quotient/remainder are valid.
module spmap_divider #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         fin,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);

  localparam int unsigned CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q, rem_d;
  logic [W-1:0]     quo_q, quo_d;
  logic [W-1:0]     dvs_q, dvs_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             fin_q, fin_d;
  logic [W:0]       rem_sh;
  logic [W:0]       diff;
  logic             unused_diff_msb;
  logic             step_en;

  assign step_en         = go | busy_q;
  assign unused_diff_msb = diff[W];

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    fin_d  = 1'b0;
    rem_sh = {rem_q, quo_q[W-1]};
    diff   = rem_sh - {1'b0, dvs_q};
    if (go) begin
      rem_d  = '0;
      quo_d  = dividend;
      dvs_d  = divisor;
      cnt_d  = CNT_W'(W);
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (rem_sh >= {1'b0, dvs_q}) begin
        rem_d = diff[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_d = rem_sh[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b0};
      end
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        fin_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      if (step_en) begin
        rem_q <= rem_d;
        quo_q <= quo_d;
        dvs_q <= dvs_d;
        cnt_q <= cnt_d;
      end
      busy_q <= busy_d;
      fin_q  <= fin_d;
    end
  end

  assign fin       = fin_q;
  assign quotient  = quo_q;
  assign remainder = rem_q;

endmodule

// File: rtl/spmap_addr_walk.sv
// Tracks the current buffer index and position inside it, and forms the
// RAM byte address. Buffer stride must be a power of two.
module spmap_addr_walk #(
  parameter int unsigned NUM_BUFS   = 8,
  parameter int unsigned BUF_STRIDE = 64,
  parameter int unsigned BUF_BASE   = 32'h1000,
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned IDX_W      = $clog2(NUM_BUFS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [IDX_W-1:0]  load_idx,
  input  logic [CNT_W-1:0]  load_pos,
  input  logic              step,
  input  logic [CNT_W-1:0]  share,
  output logic [ADDR_W-1:0] addr
);

  localparam int unsigned     STRIDE_SH = $clog2(BUF_STRIDE);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BUFS - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] pos_q, pos_d;
  logic [CNT_W:0]   pos_inc;
  logic             at_edge;
  logic             walk_en;

  assign walk_en = load | step;
  assign pos_inc = {1'b0, pos_q} + 1'b1;
  // Leave a buffer only when its share is used up; the last one absorbs the rest.
  assign at_edge = (idx_q != LAST_IDX) && (pos_inc >= {1'b0, share});

  always_comb begin
    idx_d = idx_q;
    pos_d = pos_q;
    if (load) begin
      idx_d = load_idx;
      pos_d = load_pos;
    end else if (step) begin
      if (at_edge) begin
        idx_d = idx_q + 1'b1;
        pos_d = '0;
      end else begin
        pos_d = pos_inc[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      pos_q <= '0;
    end else if (walk_en) begin
      idx_q <= idx_d;
      pos_q <= pos_d;
    end
  end

  assign addr = ADDR_W'(BUF_BASE) + (ADDR_W'(idx_q) << STRIDE_SH) + ADDR_W'(pos_q);

endmodule

// File: rtl/spmap_ctrl.sv
// Request intake, divider sequencing, host handshakes and completion.
module spmap_ctrl
  import spmap_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned LEN_W    = 9,
  parameter int unsigned NUM_BUFS = 8,
  parameter int unsigned IDX_W    = $clog2(NUM_BUFS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  input  logic [CNT_W-1:0] start_offset,
  input  logic [LEN_W-1:0] start_len,
  input  logic             start_write,
  output logic             start_ready,
  input  logic             wr_valid,
  input  logic             rd_ready,
  output logic             wr_ready,
  output logic             rd_valid,
  output logic             ram_wen,
  input  logic [CNT_W-1:0] cfg_spare,
  input  logic [CNT_W-1:0] chunk_cnt,
  output logic             div_go,
  output logic [CNT_W-1:0] div_dividend,
  output logic [CNT_W-1:0] div_divisor,
  input  logic             div_fin,
  input  logic [CNT_W-1:0] div_quo,
  input  logic [CNT_W-1:0] div_rem,
  output logic             walk_load,
  output logic [IDX_W-1:0] walk_idx,
  output logic [CNT_W-1:0] walk_pos,
  output logic             walk_step,
  output logic [CNT_W-1:0] share,
  output logic             done
);

  localparam logic [CNT_W-1:0] LAST_K = CNT_W'(NUM_BUFS - 1);

  spmap_state_e     state_q, state_d;
  logic [LEN_W-1:0] remain_q, remain_d;
  logic [CNT_W-1:0] off_q;
  logic [CNT_W-1:0] sb_q;
  logic             wr_q;
  logic             done_q, done_d;
  logic             accept;
  logic             beat;
  logic             sb_en;
  logic [CNT_W-1:0] sb_even;
  logic [CNT_W-1:0] last_base;
  logic             clamp;

  assign accept    = start_valid && (state_q == ST_IDLE);
  assign beat      = (state_q == ST_MOVE) && (wr_q ? wr_valid : rd_ready);
  assign sb_even   = {div_quo[CNT_W-1:1], 1'b0};
  assign sb_en     = (state_q == ST_DIV_SHARE) && div_fin;

  // Divider operands: first the share, then the start position.
  assign div_go       = (accept && (start_len != '0)) || sb_en;
  assign div_dividend = (state_q == ST_DIV_SHARE) ? off_q   : cfg_spare;
  assign div_divisor  = (state_q == ST_DIV_SHARE) ? sb_even : chunk_cnt;

  // Start position: clamp the buffer index, spill the rest into the last one.
  assign last_base = sb_q * LAST_K;
  assign clamp     = div_quo > LAST_K;
  assign walk_idx  = clamp ? IDX_W'(NUM_BUFS - 1) : div_quo[IDX_W-1:0];
  assign walk_pos  = clamp ? (off_q - last_base) : div_rem;
  assign walk_load = (state_q == ST_DIV_POS) && div_fin;
  assign walk_step = beat;
  assign share     = sb_q;

  assign start_ready = (state_q == ST_IDLE);
  assign wr_ready    = (state_q == ST_MOVE) && wr_q;
  assign rd_valid    = (state_q == ST_MOVE) && !wr_q;
  assign ram_wen     = wr_ready && wr_valid;
  assign done        = done_q;

  always_comb begin
    state_d  = state_q;
    remain_d = remain_q;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          remain_d = start_len;
          if (start_len == '0) done_d  = 1'b1;
          else                 state_d = ST_DIV_SHARE;
        end
      end
      ST_DIV_SHARE: begin
        if (div_fin) state_d = ST_DIV_POS;
      end
      ST_DIV_POS: begin
        if (div_fin) state_d = ST_MOVE;
      end
      ST_MOVE: begin
        if (beat) begin
          remain_d = remain_q - 1'b1;
          if (remain_q == LEN_W'(1)) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      off_q    <= '0;
      wr_q     <= 1'b0;
      sb_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (accept || beat) remain_q <= remain_d;
      if (accept) begin
        off_q <= start_offset;
        wr_q  <= start_write;
      end
      if (sb_en) sb_q <= sb_even;
    end
  end

endmodule

// File: rtl/spare_chunk_mapper.sv
module spare_chunk_mapper #(
  parameter int unsigned NUM_BUFS    = 8,
  parameter int unsigned BUF_STRIDE  = 64,
  parameter int unsigned BUF_BASE    = 32'h1000,
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned PAGE_W      = 13,
  parameter int unsigned CHUNK_SHIFT = 9,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned LEN_W       = 9,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] cfg_page_bytes,
  input  logic [CNT_W-1:0]  cfg_spare_bytes,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [CNT_W-1:0]  start_offset,
  input  logic [LEN_W-1:0]  start_len,
  input  logic              start_write,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_wen,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              done
);

  localparam int unsigned IDX_W = $clog2(NUM_BUFS);

  logic [CNT_W-1:0] chunk_cnt;
  logic             unused_page_lsb;
  logic             div_go, div_fin;
  logic [CNT_W-1:0] div_dividend, div_divisor, div_quo, div_rem;
  logic             walk_load, walk_step;
  logic [IDX_W-1:0] walk_idx;
  logic [CNT_W-1:0] walk_pos;
  logic [CNT_W-1:0] share;

  // One chunk per 512 main bytes: a plain shift of the page size.
  assign chunk_cnt       = CNT_W'(cfg_page_bytes[PAGE_W-1:CHUNK_SHIFT]);
  assign unused_page_lsb = ^cfg_page_bytes[CHUNK_SHIFT-1:0];

  spmap_ctrl #(
    .CNT_W    (CNT_W),
    .LEN_W    (LEN_W),
    .NUM_BUFS (NUM_BUFS),
    .IDX_W    (IDX_W)
  ) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_valid  (start_valid),
    .start_offset (start_offset),
    .start_len    (start_len),
    .start_write  (start_write),
    .start_ready  (start_ready),
    .wr_valid     (wr_valid),
    .rd_ready     (rd_ready),
    .wr_ready     (wr_ready),
    .rd_valid     (rd_valid),
    .ram_wen      (ram_wen),
    .cfg_spare    (cfg_spare_bytes),
    .chunk_cnt    (chunk_cnt),
    .div_go       (div_go),
    .div_dividend (div_dividend),
    .div_divisor  (div_divisor),
    .div_fin      (div_fin),
    .div_quo      (div_quo),
    .div_rem      (div_rem),
    .walk_load    (walk_load),
    .walk_idx     (walk_idx),
    .walk_pos     (walk_pos),
    .walk_step    (walk_step),
    .share        (share),
    .done         (done)
  );

  spmap_divider #(
    .W (CNT_W)
  ) i_divider (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (div_go),
    .dividend  (div_dividend),
    .divisor   (div_divisor),
    .fin       (div_fin),
    .quotient  (div_quo),
    .remainder (div_rem)
  );

  spmap_addr_walk #(
    .NUM_BUFS   (NUM_BUFS),
    .BUF_STRIDE (BUF_STRIDE),
    .BUF_BASE   (BUF_BASE),
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .IDX_W      (IDX_W)
  ) i_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (walk_load),
    .load_idx (walk_idx),
    .load_pos (walk_pos),
    .step     (walk_step),
    .share    (share),
    .addr     (ram_addr)
  );

  assign ram_wdata = wr_data;
  assign rd_data   = ram_rdata;

endmodule

// File: rtl/spmap_checker.sv
module spmap_checker #(
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned LEN_W    = 9,
  parameter int unsigned BUF_BASE = 32'h1000,
  parameter int unsigned BUF_SPAN = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_valid,
  input logic              start_ready,
  input logic [LEN_W-1:0]  start_len,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_wen,
  input logic              done
);

  localparam logic [ADDR_W-1:0] LO = ADDR_W'(BUF_BASE);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(BUF_BASE + BUF_SPAN);

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_BUSY_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || wr_ready) |-> !start_ready); // R7

  AST_ZERO_LEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready && (start_len == '0)) |=> (done && !ram_wen && !rd_valid)); // R8

  AST_READ_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(ram_addr))); // R6

  AST_WRITE_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !wr_valid) |=> (wr_ready && $stable(ram_addr))); // R5

  AST_SINGLE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!wr_ready && !ram_wen)); // R6

  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || ram_wen) |-> ((ram_addr >= LO) && (ram_addr < HI))); // R2

endmodule

bind spare_chunk_mapper spmap_checker #(
  .ADDR_W   (ADDR_W),
  .LEN_W    (LEN_W),
  .BUF_BASE (BUF_BASE),
  .BUF_SPAN (NUM_BUFS * BUF_STRIDE)
) i_spmap_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_valid (start_valid),
  .start_ready (start_ready),
  .start_len   (start_len),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .ram_addr    (ram_addr),
  .ram_wen     (ram_wen),
  .done        (done)
);

// File: tb/test_spare_chunk_mapper.sv
`timescale 1ns/1ps
module test_spare_chunk_mapper;

  logic        clk;
  logic        rst_n;
  logic [12:0] cfg_page_bytes;
  logic [7:0]  cfg_spare_bytes;
  logic        start_valid;
  logic        start_ready;
  logic [7:0]  start_offset;
  logic [8:0]  start_len;
  logic        start_write;
  logic        wr_valid;
  logic        wr_ready;
  logic [7:0]  wr_data;
  logic        rd_valid;
  logic        rd_ready;
  logic [7:0]  rd_data;
  logic [12:0] ram_addr;
  logic        ram_wen;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata;
  logic        done;

  int checks;
  int failures;
  int cyc;

  logic [7:0] mem [0:511];
  logic       in_win;
  logic [8:0] mem_idx;

  spare_chunk_mapper i_spare_chunk_mapper (
    .clk(clk), .rst_n(rst_n),
    .cfg_page_bytes(cfg_page_bytes), .cfg_spare_bytes(cfg_spare_bytes),
    .start_valid(start_valid), .start_ready(start_ready),
    .start_offset(start_offset), .start_len(start_len), .start_write(start_write),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .ram_addr(ram_addr), .ram_wen(ram_wen), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Buffer RAM model: combinational read, write on the clock edge
  assign in_win    = (ram_addr >= 13'h1000) && (ram_addr < 13'h1200);
  assign mem_idx   = ram_addr[8:0];
  assign ram_rdata = in_win ? mem[mem_idx] : 8'h00;
  always @(posedge clk) if (ram_wen && in_win) mem[mem_idx] <= ram_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference mapping from the requirements (R1, R2)
  function automatic int exp_addr(input int page, input int spare, input int pos);
    int chunks, sb, k;
    chunks = page / 512;
    sb     = (spare / chunks) & ~1;
    k      = pos / sb;
    if (k > 7) k = 7;
    return 'h1000 + k * 64 + (pos - k * sb);
  endfunction

  task automatic run_xfer(input int page, input int spare, input int off, input int len,
                          input bit wr, input int stall, input string tag);
    int moved;
    int waitc;
    int ea;
    cfg_page_bytes  = 13'(page);
    cfg_spare_bytes = 8'(spare);
    @(negedge clk);
    start_offset = 8'(off);
    start_len    = 9'(len);
    start_write  = wr;
    start_valid  = 1'b1;
    #1;
    chk(start_ready == 1'b1, {tag, " R7 start_ready idle"}, start_ready, 1);
    @(posedge clk);
    #1 start_valid = 1'b0;
    if (len == 0) begin
      @(negedge clk);
      #1;
      chk(done == 1'b1, {tag, " R8 done after zero length"}, done, 1);
      chk(ram_wen == 1'b0 && rd_valid == 1'b0, {tag, " R8 no ram traffic"}, {ram_wen, rd_valid}, 0);
      @(negedge clk);
      #1;
      chk(done == 1'b0, {tag, " R7 done single cycle"}, done, 0);
      return;
    end
    moved = 0;
    waitc = 0;
    while (moved < len && waitc < 3000) begin
      @(negedge clk);
      wr_valid = wr && ($urandom_range(99) >= 32'(stall));
      wr_data  = 8'($urandom);
      rd_ready = !wr && ($urandom_range(99) >= 32'(stall));
      #1;
      waitc++;
      if (done !== 1'b0) chk(1'b0, {tag, " R7 done early"}, done, 0);
      if (wr) begin
        if (rd_valid !== 1'b0) chk(1'b0, {tag, " R5 rd_valid in write"}, rd_valid, 0);
        if (wr_valid && wr_ready) begin
          ea = exp_addr(page, spare, off + moved);
          chk(ram_wen == 1'b1, {tag, " R5 write strobe"}, ram_wen, 1);
          chk(32'(ram_addr) == ea, {tag, " R2 R3 write address"}, ram_addr, ea);
          chk(ram_wdata == wr_data, {tag, " R5 write data"}, ram_wdata, wr_data);
          moved++;
        end else if (ram_wen !== 1'b0) begin
          chk(1'b0, {tag, " R5 write without valid"}, ram_wen, 0);
        end
        if (wr_ready === 1'b1 && start_ready !== 1'b0)
          chk(1'b0, {tag, " R7 start_ready busy"}, start_ready, 0);
      end else begin
        if (wr_ready !== 1'b0 || ram_wen !== 1'b0)
          chk(1'b0, {tag, " R6 write path in read"}, {wr_ready, ram_wen}, 0);
        if (rd_valid && rd_ready) begin
          ea = exp_addr(page, spare, off + moved);
          chk(32'(ram_addr) == ea, {tag, " R2 R3 read address"}, ram_addr, ea);
          chk(rd_data == mem[9'(ea - 'h1000)], {tag, " R6 read data"}, rd_data, mem[9'(ea - 'h1000)]);
          moved++;
        end
      end
    end
    chk(moved == len, {tag, " R7 all bytes moved"}, moved, len);
    @(negedge clk);
    wr_valid = 1'b0;
    rd_ready = 1'b0;
    #1;
    chk(done == 1'b1, {tag, " R7 done after last byte"}, done, 1);
    @(negedge clk);
    #1;
    chk(done == 1'b0 && start_ready == 1'b1, {tag, " R7 done one cycle"}, {done, start_ready}, 2'b01);
  endtask

  // Watchdog
  initial cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc >= 190000) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int pages [4];
    int spares[4];
    void'($urandom(32'd20240611));
    pages  = '{512, 2048, 4096, 4096};
    spares = '{16, 64, 128, 218};
    checks = 0;
    failures = 0;
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 37 + 11);
    rst_n = 1'b0;
    cfg_page_bytes = 13'd2048;
    cfg_spare_bytes = 8'd64;
    start_valid = 1'b0;
    start_offset = '0;
    start_len = '0;
    start_write = 1'b0;
    wr_valid = 1'b0;
    wr_data = '0;
    rd_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(start_ready == 1'b1 && done == 1'b0, "R7 reset idle", {start_ready, done}, 2'b10);
    chk(wr_ready == 1'b0 && rd_valid == 1'b0 && ram_wen == 1'b0, "R5 R6 reset quiet",
        {wr_ready, rd_valid, ram_wen}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: whole spare area of every pair, written then read back
    for (int p = 0; p < 4; p++) begin
      run_xfer(pages[p], spares[p], 0, spares[p], 1'b1, 0, "R4 full write");
      run_xfer(pages[p], spares[p], 0, spares[p], 1'b0, 0, "R4 full read");
    end

    // R3: crossing a buffer edge (share 16 for 2048/64)
    run_xfer(2048, 64, 14, 4, 1'b1, 0, "R3 edge write");
    run_xfer(2048, 64, 14, 4, 1'b0, 30, "R3 edge read");
    run_xfer(4096, 128, 15, 3, 1'b0, 0, "R3 edge read 128");

    // R2: share 26 for 4096/218, spill bytes 208..217 into buffer 7
    run_xfer(4096, 218, 200, 18, 1'b1, 40, "R2 spill write");
    run_xfer(4096, 218, 210, 8, 1'b0, 40, "R2 spill read");

    // R8: zero-length requests in both directions
    run_xfer(4096, 218, 5, 0, 1'b1, 0, "R8 zero write");
    run_xfer(512, 16, 3, 0, 1'b0, 0, "R8 zero read");

    // R5 R6: heavy stalls
    run_xfer(2048, 64, 0, 40, 1'b1, 80, "R5 stalled write");
    run_xfer(2048, 64, 5, 40, 1'b0, 80, "R6 stalled read");

    // R1: random mix
    for (int n = 0; n < 60; n++) begin
      int sel;
      int off;
      int len;
      sel = int'($urandom_range(3));
      off = int'($urandom_range(32'(spares[sel] - 1)));
      len = int'($urandom_range(32'(spares[sel] - off)));
      run_xfer(pages[sel], spares[sel], off, len, 1'($urandom_range(1)),
               int'($urandom_range(60)), "R1 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule